// File: doc/BRIEF.md
# Edge-Interval Bit-Check Validator

This block sits after a receiver's demodulator and decides whether the demodulated stream is a genuine transmission or noise. It measures, in clock cycles, the gap between consecutive transitions of the demodulated signal and compares each gap with a programmable window given by a lower and an upper limit. A start pulse begins a qualification run. The run asks for a coded number of bits, and each bit costs two interval checks.

When every required interval lands inside the window, the block enters receiving mode and forwards the synchronized demodulated level to its data output. A gap that is too short ends the run in sleep mode. So does a silence that outlasts the upper limit, and the timeout fires without waiting for a further transition. The two limits are inputs, so the window can be retuned between runs for a different data rate.

Top module: `edge_window_qualifier`

## Requirements
- R1: After reset the block is idle, and `data_o`, `rx_mode_o` and `sleep_o` are all 0.
- R2: `nbits_code_i` is sampled with an accepted start. It selects the bits to check: 2'b00 selects 0 bits, 2'b01 selects 3, 2'b10 selects 6 and 2'b11 selects 9. The run then needs 0, 6, 12 or 18 passing interval checks, two per bit.
- R3: An interval is the number of clock cycles between two consecutive detected transitions, rising or falling. The first transition after start only begins timing and is not checked. An interval with `lim_lo_i` <= interval <= `lim_hi_i` passes, and both limits count as inside the window.
- R4: A transition that closes an interval shorter than `lim_lo_i` ends the run, and `sleep_o` goes to 1.
- R5: Once timing has begun, if more than `lim_hi_i` cycles pass with no transition, the run ends with `sleep_o` = 1 and no further transition is needed.
- R6: When the last required check passes, `rx_mode_o` goes to 1. With one check still missing, both `rx_mode_o` and `sleep_o` stay 0.
- R7: `data_o` is 0 whenever `rx_mode_o` is 0. In receiving mode, `data_o` equals `demod_i` delayed by the two-stage synchronizer (two clock edges).
- R8: An accepted start with code 2'b00 puts the block in receiving mode at the next clock edge.
- R9: A start is accepted in the idle, sleep and receiving states and clears the pass and interval counters. A start that arrives while a check run is in progress is ignored.
- R10: The interval counter saturates at all ones instead of wrapping. With `lim_hi_i` at all ones, an arbitrarily long silence therefore never times out.
- R11: `rx_mode_o` and `sleep_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a qualification run |
| demod_i | input | 1 | Demodulated data (asynchronous) |
| nbits_code_i | input | 2 | Coded number of bits to check |
| lim_lo_i | input | CNT_W | Lower interval limit in cycles |
| lim_hi_i | input | CNT_W | Upper interval limit in cycles |
| data_o | output | 1 | Forwarded data, 0 outside receiving mode |
| rx_mode_o | output | 1 | Receiving mode reached |
| sleep_o | output | 1 | Run failed, sleep requested |

## Verification
The bench builds the block with `CNT_W` = 8 and two synchronizer stages. The 8-bit counter makes saturation reachable within a few hundred cycles: a 300-cycle silence with the upper limit at 255 shows that the counter neither wraps nor times out. The window 4..10 lets the bench place gaps exactly at each limit and one cycle outside it, and runs with all four count codes test the exact number of checks per code.

// File: rtl/ewq_pkg.sv
package ewq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_RECV  = 2'd2,
      ST_SLEEP = 2'd3
   } ewq_state_e;
endpackage

// File: rtl/ewq_sync.sv
module ewq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic edge_o
);
   localparam int MSB = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("ewq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[MSB-1:0], async_i};
         last_q  <= chain_q[MSB];
      end
   end

   assign level_o = chain_q[MSB];
   assign edge_o  = chain_q[MSB] ^ last_q;
endmodule

// File: rtl/ewq_span_counter.sv
module ewq_span_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         restart_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   if (W < 2) begin : g_bad_width
      $error("ewq_span_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= ONE;
      end else if (inc_i && (cnt_q != TOP)) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ewq_ctrl.sv
module ewq_ctrl
   import ewq_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int BITS_STEP      = 3,
   parameter int CHECKS_PER_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       code_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] span_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   output ewq_state_e       state_o,
   output logic             armed_o,
   output logic             cnt_clear_o,
   output logic             cnt_restart_o,
   output logic             cnt_inc_o
);
   localparam int STEP     = BITS_STEP * CHECKS_PER_BIT;
   localparam int MAX_PASS = 3 * STEP;
   localparam int PASS_W   = $clog2(MAX_PASS + 1);

   if (BITS_STEP < 1 || CHECKS_PER_BIT < 1) begin : g_bad_step
      $error("ewq_ctrl: BITS_STEP and CHECKS_PER_BIT must be positive");
   end

   ewq_state_e        state_q;
   logic              armed_q;
   logic [PASS_W-1:0] passes_q;
   logic [PASS_W-1:0] target_q;
   logic [PASS_W-1:0] target_d;
   logic [PASS_W-1:0] passes_nx;
   logic              start_ok;
   logic              in_check;

   assign start_ok  = start_i && (state_q != ST_CHECK);
   assign in_check  = (state_q == ST_CHECK);
   assign target_d  = PASS_W'(code_i) * PASS_W'(STEP);
   assign passes_nx = passes_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         armed_q  <= 1'b0;
         passes_q <= '0;
         target_q <= '0;
      end else if (start_ok) begin
         armed_q  <= 1'b0;
         passes_q <= '0;
         target_q <= target_d;
         state_q  <= (target_d == '0) ? ST_RECV : ST_CHECK;
      end else if (in_check) begin
         if (!armed_q) begin
            if (edge_i) armed_q <= 1'b1;
         end else if (span_i > lim_hi_i) begin
            state_q <= ST_SLEEP;
         end else if (edge_i) begin
            if (span_i < lim_lo_i) begin
               state_q <= ST_SLEEP;
            end else if (passes_nx == target_q) begin
               passes_q <= passes_nx;
               state_q  <= ST_RECV;
            end else begin
               passes_q <= passes_nx;
            end
         end
      end
   end

   assign state_o       = state_q;
   assign armed_o       = armed_q;
   assign cnt_clear_o   = start_ok;
   assign cnt_restart_o = in_check && edge_i && !start_ok;
   assign cnt_inc_o     = in_check && armed_q;
endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier
   import ewq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             demod_i,
   input  logic [1:0]       nbits_code_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   output logic             data_o,
   output logic             rx_mode_o,
   output logic             sleep_o
);
   ewq_state_e       state_w;
   logic             armed_w;
   logic             level_w;
   logic             edge_w;
   logic             clr_w;
   logic             rst_cnt_w;
   logic             inc_w;
   logic [CNT_W-1:0] span_w;

   ewq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (demod_i),
      .level_o (level_w),
      .edge_o  (edge_w)
   );

   ewq_span_counter #(.W(CNT_W)) u_span (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clr_w),
      .restart_i (rst_cnt_w),
      .inc_i     (inc_w),
      .cnt_o     (span_w)
   );

   ewq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .code_i        (nbits_code_i),
      .edge_i        (edge_w),
      .span_i        (span_w),
      .lim_lo_i      (lim_lo_i),
      .lim_hi_i      (lim_hi_i),
      .state_o       (state_w),
      .armed_o       (armed_w),
      .cnt_clear_o   (clr_w),
      .cnt_restart_o (rst_cnt_w),
      .cnt_inc_o     (inc_w)
   );

   assign rx_mode_o = (state_w == ST_RECV);
   assign sleep_o   = (state_w == ST_SLEEP);
   assign data_o    = rx_mode_o & level_w;
endmodule

// File: rtl/ewq_checker.sv
module ewq_checker
   import ewq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             demod_i,
   input logic [1:0]       nbits_code_i,
   input logic             data_o,
   input logic             rx_mode_o,
   input logic             sleep_o,
   input ewq_state_e       state_w,
   input logic             armed_w,
   input logic             edge_w,
   input logic [CNT_W-1:0] span_w
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_mode_o && sleep_o));

   p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mode_o && $past(rx_mode_o, 2)) |-> (data_o == $past(demod_i, 2)));

   p_zero_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && nbits_code_i == 2'b00 && state_w != ST_CHECK) |=> rx_mode_o);

   p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !start_i) |=> sleep_o);

   p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_CHECK && armed_w && span_w == TOP && !edge_w && !start_i)
      |=> (span_w == TOP));

   p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_CHECK && armed_w && start_i && !edge_w && span_w != TOP && span_w != '0)
      |=> (span_w != '0));
endmodule

bind edge_window_qualifier ewq_checker #(.CNT_W(CNT_W)) u_ewq_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .demod_i      (demod_i),
   .nbits_code_i (nbits_code_i),
   .data_o       (data_o),
   .rx_mode_o    (rx_mode_o),
   .sleep_o      (sleep_o),
   .state_w      (state_w),
   .armed_w      (armed_w),
   .edge_w       (edge_w),
   .span_w       (span_w)
);

// File: tb/edge_window_qualifier_bench.sv
module edge_window_qualifier_bench;
   localparam int CNT_W  = 8;
   localparam int OUT_RX = 1;
   localparam int OUT_SL = 2;

   typedef struct {
      int    outcome;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic             demod_i = 1'b0;
   logic [1:0]       nbits_code_i = 2'b00;
   logic [CNT_W-1:0] lim_lo_i = 8'd4;
   logic [CNT_W-1:0] lim_hi_i = 8'd10;
   logic             data_o, rx_mode_o, sleep_o;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   bit   both_seen = 1'b0;
   logic prev_rx = 1'b0;
   logic prev_sl = 1'b0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   edge_window_qualifier #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_edge_window_qualifier (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .demod_i      (demod_i),
      .nbits_code_i (nbits_code_i),
      .lim_lo_i     (lim_lo_i),
      .lim_hi_i     (lim_hi_i),
      .data_o       (data_o),
      .rx_mode_o    (rx_mode_o),
      .sleep_o      (sleep_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // monitor: each new rising outcome is compared with the scoreboard head
   task automatic got(input int outcome);
      exp_t e;
      if (sb_q.size() == 0) begin
         check(1'b0, "R6 unexpected outcome", outcome, 0);
      end else begin
         e = sb_q.pop_front();
         check(outcome == e.outcome, e.req, outcome, e.outcome);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_mode_o && sleep_o) both_seen = 1'b1;
         if (rx_mode_o && !prev_rx) got(OUT_RX);
         if (sleep_o && !prev_sl) got(OUT_SL);
         prev_rx = rx_mode_o;
         prev_sl = sleep_o;
      end
   end

   task automatic begin_run(input logic [1:0] code, input int outcome, input string req);
      exp_t e;
      e.outcome = outcome;
      e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
      start_i = 1'b1;
      nbits_code_i = code;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic flip_after(input int gap);
      repeat (gap) @(negedge clk);
      demod_i = ~demod_i;
   endtask

   // full passing run with a mid-run check before the last interval
   task automatic pass_run(input logic [1:0] code, input int gap, input string req);
      int n;
      n = int'(code) * 6;
      begin_run(code, OUT_RX, req);
      flip_after(3);
      for (int i = 0; i < n; i++) begin
         repeat (gap) @(negedge clk);
         if (i == n - 1)
            check(!rx_mode_o && !sleep_o, "R6 one check short stays checking",
                  {rx_mode_o, sleep_o}, 0);
         demod_i = ~demod_i;
      end
      repeat (6) @(negedge clk);
      check(rx_mode_o == 1'b1, req, rx_mode_o, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!data_o && !rx_mode_o && !sleep_o, "R1 reset outputs",
            {data_o, rx_mode_o, sleep_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!data_o && !rx_mode_o && !sleep_o, "R1 idle after reset",
            {data_o, rx_mode_o, sleep_o}, 0);

      // R2 R3 R6: 3 bits -> 6 checks
      pass_run(2'b01, 6, "R2 code 01 needs 6 checks");

      // R7 passthrough in receiving mode
      demod_i = 1'b1;
      repeat (3) @(negedge clk);
      check(data_o == 1'b1, "R7 data follows high", data_o, 1);
      demod_i = 1'b0;
      repeat (3) @(negedge clk);
      check(data_o == 1'b0, "R7 data follows low", data_o, 0);

      // R9 restart from receive, code 10 -> 12 checks, gaps on both limits (R3),
      // a start during checking is ignored
      begin_run(2'b10, OUT_RX, "R3 limits inclusive, 12 checks");
      check(rx_mode_o == 1'b0, "R9 start accepted from receive", rx_mode_o, 0);
      flip_after(3);
      for (int i = 0; i < 12; i++) begin
         int gap;
         gap = (i % 2 == 0) ? 4 : 10;
         if (i == 5) begin
            repeat (2) @(negedge clk);
            start_i = 1'b1;
            nbits_code_i = 2'b00;
            @(negedge clk);
            start_i = 1'b0;
            check(!rx_mode_o && !sleep_o, "R9 start ignored while checking",
                  {rx_mode_o, sleep_o}, 0);
            repeat (gap - 3) @(negedge clk);
         end else begin
            repeat (gap) @(negedge clk);
         end
         if (i == 7) check(data_o == 1'b0, "R7 data held low while checking", data_o, 0);
         if (i == 11) check(rx_mode_o == 1'b0, "R6 R9 not early", rx_mode_o, 0);
         demod_i = ~demod_i;
      end
      repeat (6) @(negedge clk);
      check(rx_mode_o == 1'b1, "R3 run at limits reaches receive", rx_mode_o, 1);

      // R4 too-short interval (lim_lo - 1)
      begin_run(2'b11, OUT_SL, "R4 short interval sleeps");
      flip_after(3);
      flip_after(6);
      flip_after(6);
      flip_after(3);
      repeat (6) @(negedge clk);
      check(sleep_o == 1'b1 && data_o == 1'b0, "R4 sleep and data low",
            {sleep_o, data_o}, 2);

      // R5 timeout without a further edge (start from sleep, R9)
      begin_run(2'b01, OUT_SL, "R5 silence times out");
      check(sleep_o == 1'b0, "R9 start accepted from sleep", sleep_o, 0);
      flip_after(3);
      flip_after(6);
      repeat (20) @(negedge clk);
      check(sleep_o == 1'b1, "R5 sleep after silence", sleep_o, 1);

      // R5 interval of lim_hi + 1
      begin_run(2'b01, OUT_SL, "R5 interval above upper limit");
      flip_after(3);
      flip_after(11);
      repeat (6) @(negedge clk);
      check(sleep_o == 1'b1, "R5 hi+1 sleeps", sleep_o, 1);

      // R2: 9 bits -> 18 checks, from sleep with cleared counters
      pass_run(2'b11, 7, "R2 code 11 needs 18 checks");

      // R8: zero bits
      begin_run(2'b11, OUT_SL, "R5 timeout before zero-bit run");
      repeat (20) @(negedge clk);
      check(sleep_o == 1'b0, "R3 first edge needed before timing", sleep_o, 0);
      flip_after(1);
      repeat (20) @(negedge clk);
      begin_run(2'b00, OUT_RX, "R8 zero-bit code");
      check(rx_mode_o == 1'b1, "R8 receive one edge after start", rx_mode_o, 1);

      // R10 saturation with lim_hi all ones
      lim_lo_i = 8'd1;
      lim_hi_i = 8'hFF;
      begin_run(2'b01, OUT_RX, "R10 saturated run completes");
      flip_after(3);
      repeat (300) @(negedge clk);
      check(!sleep_o && !rx_mode_o, "R10 no timeout when saturated",
            {rx_mode_o, sleep_o}, 0);
      demod_i = ~demod_i;
      for (int i = 0; i < 5; i++) flip_after(5);
      repeat (6) @(negedge clk);
      check(rx_mode_o == 1'b1, "R10 receive after saturated interval", rx_mode_o, 1);

      check(sb_q.size() == 0, "R6 all expected outcomes seen", sb_q.size(), 0);
      check(!both_seen, "R11 outputs exclusive", both_seen, 0);
      finished = 1'b1;
      report();
   end
endmodule